// File: doc/BRIEF.md
# Triplicable Timer and Event Counter Bank

The block holds nine physical 32-bit counter channels behind a flat register port. In normal operation software sees channels 0 to 7. Each visible channel can be set up in one of two ways. As a free-running timer it counts clock cycles. As an event counter it counts the cycles in which one chosen line out of a 256-line event bus is high. Each visible channel also keeps a sticky match flag, which can drive that channel's interrupt line. The ninth channel has no address and only comes into use for redundancy.

When the triplication input is high, the nine channels form three groups: {0,1,2}, {3,4,5} and {6,7,8}. Each group acts as one logical counter, addressed as channels 0, 1 and 2. A register write to logical counter k reaches all three members of group k. Every state bit of the three members passes through a bitwise 2-of-3 majority voter. Register reads and interrupts use the voted value. On every cycle the voted value is also loaded back into all three members, so a member that has drifted is brought back into line.

Top module: `tmr_counter_bank`

## Requirements
- R1: After the asynchronous active-low reset, every channel register reads 0 and all interrupt outputs are low.
- R2: The register address is {channel[2:0], reg[1:0]}. Reg 0 is control: bit 0 enable, bit 1 mode (0 timer, 1 event), bits 9:2 event select, bit 10 interrupt enable, and all other bits read 0. Reg 1 is count, reg 2 is compare and reg 3 is the match flag in bit 0. A write takes effect at the next clock edge. Reads are combinational.
- R3: In timer mode, an enabled channel's count rises by one at every clock edge. A disabled channel holds its count.
- R4: In event mode, an enabled channel's count rises by one at each clock edge where the event line picked by the select field is high. Other event lines have no effect.
- R5: A write to count loads the written value. The count wraps from 0xFFFFFFFF to 0.
- R6: The match flag is set at a clock edge where the channel is enabled and its count equals its compare value. The flag stays set until bit 0 of the flag register is written with 1. Writing 0 leaves it unchanged. If a set and a clear arrive in the same cycle, the set wins.
- R7: Each interrupt output is the channel's match flag ANDed with its interrupt enable.
- R8: With triplication low, channels 0 to 7 run independently of one another.
- R9: With triplication high, a write to logical channel k (0 to 2) updates all three physical channels 3k, 3k+1 and 3k+2.
- R10: With triplication high, reads and interrupt k return the bitwise majority of group k.
- R11: With triplication high, the voted state is written back into all three members of each group at every clock edge.
- R12: With triplication high, logical channels 3 to 7 read 0, ignore writes, and drive their interrupts low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tmr_en_i | input | 1 | Selects triplicated mode |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | {channel, register} address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| events_i | input | 256 | Event source lines |
| irq_o | output | 8 | Per-channel interrupt lines |

## Verification
Timer mode is checked over runs of enabled and disabled cycles. Event mode is checked with a non-selected line held high and then with the selected line high, which shows that the select field alone decides what is counted. The voter is loaded with three members that differ bit by bit, so a true majority can be told apart from a copy of one member. Leaving triplicated mode then exposes each member through the normal read path. This makes the write-back correction, the broadcast of logical writes and the rejection of writes to hidden logical channels all visible at the ports.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  parameter int unsigned CNT_W = 32;
  parameter int unsigned EV_W  = 256;
  localparam int unsigned SEL_W = $clog2(EV_W);

  typedef struct packed {
    logic             ie;
    logic [SEL_W-1:0] sel;
    logic             mode;   // 0 timer, 1 event
    logic             en;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  typedef struct packed {
    ctrl_t            ctrl;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cmp;
    logic             flag;
  } chan_st_t;

  localparam int unsigned ST_W = $bits(chan_st_t);
endpackage

// File: rtl/cnt_maj3.sv
module cnt_maj3 #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] y_o
);
  assign y_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
endmodule

// File: rtl/cnt_channel.sv
module cnt_channel
  import cnt_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  chan_st_t        src_i,     // own state, or voted state in tmr mode
  input  logic            ctrl_we_i,
  input  logic            cnt_we_i,
  input  logic            cmp_we_i,
  input  logic            flag_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [EV_W-1:0]  events_i,
  output chan_st_t        st_o
);
  chan_st_t st_d;
  logic ev_bit, hit, clr;

  assign ev_bit = events_i[src_i.ctrl.sel];
  assign hit    = src_i.ctrl.en && (src_i.cnt == src_i.cmp);
  assign clr    = flag_we_i && wdata_i[0];

  always_comb begin
    st_d = src_i;
    if (ctrl_we_i) st_d.ctrl = ctrl_t'(wdata_i[CTRL_W-1:0]);
    if (cmp_we_i)  st_d.cmp  = wdata_i;
    if (cnt_we_i)
      st_d.cnt = wdata_i;
    else if (src_i.ctrl.en && (!src_i.ctrl.mode || ev_bit))
      st_d.cnt = src_i.cnt + CNT_W'(1);
    st_d.flag = hit | (src_i.flag & ~clr);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_o <= '0;
    else         st_o <= st_d;
  end

  AST_EVT_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_i.ctrl.en && src_i.ctrl.mode && !ev_bit && !cnt_we_i |=> st_o.cnt == $past(src_i.cnt)); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_i.flag && !clr |=> st_o.flag); // R6
endmodule

// File: rtl/tmr_counter_bank.sv
module tmr_counter_bank
  import cnt_pkg::*;
#(
  parameter int unsigned N_GRP = 3
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           tmr_en_i,
  input  logic                           wr_en_i,
  input  logic [$clog2(3*N_GRP-1)+1:0]   addr_i,
  input  logic [CNT_W-1:0]               wdata_i,
  output logic [CNT_W-1:0]               rdata_o,
  input  logic [EV_W-1:0]                events_i,
  output logic [3*N_GRP-2:0]             irq_o
);
  localparam int unsigned N_PHYS = 3 * N_GRP;
  localparam int unsigned N_VIS  = N_PHYS - 1;
  localparam int unsigned CH_AW  = $clog2(N_VIS);
  localparam int unsigned PH_IW  = $clog2(N_PHYS);
  localparam int unsigned GRP_IW = $clog2(N_GRP);

  chan_st_t st_q  [N_PHYS];
  chan_st_t voted [N_GRP];
  logic [ST_W-1:0] vote_raw [N_GRP];

  logic [CH_AW-1:0] chan;
  logic [1:0]       rsel;
  assign chan = addr_i[CH_AW+1:2];
  assign rsel = addr_i[1:0];

  for (genvar g = 0; g < N_GRP; g++) begin : g_vote
    cnt_maj3 #(.W(ST_W)) u_maj (
      .a_i(st_q[3*g]), .b_i(st_q[3*g+1]), .c_i(st_q[3*g+2]), .y_o(vote_raw[g])
    );
    assign voted[g] = chan_st_t'(vote_raw[g]);

    AST_GROUP_AGREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tmr_en_i |=> (st_q[3*g] == st_q[3*g+1]) && (st_q[3*g+1] == st_q[3*g+2])); // R11
  end

  for (genvar p = 0; p < N_PHYS; p++) begin : g_ch
    logic     sel_p;
    chan_st_t src_p;

    if (p < N_VIS) begin : g_vis
      assign sel_p = wr_en_i && (tmr_en_i ? (chan == CH_AW'(p / 3)) : (chan == CH_AW'(p)));
    end else begin : g_hid
      assign sel_p = wr_en_i && tmr_en_i && (chan == CH_AW'(p / 3));
    end

    assign src_p = tmr_en_i ? voted[p / 3] : st_q[p];

    cnt_channel u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .src_i    (src_p),
      .ctrl_we_i(sel_p && rsel == 2'd0),
      .cnt_we_i (sel_p && rsel == 2'd1),
      .cmp_we_i (sel_p && rsel == 2'd2),
      .flag_we_i(sel_p && rsel == 2'd3),
      .wdata_i  (wdata_i),
      .events_i (events_i),
      .st_o     (st_q[p])
    );

    if (p < N_VIS) begin : g_chk
      AST_TIMER_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tmr_en_i && st_q[p].ctrl.en && !st_q[p].ctrl.mode && !(sel_p && rsel == 2'd1)
        |=> st_q[p].cnt == $past(st_q[p].cnt) + CNT_W'(1)); // R3
    end
  end

  // read path
  chan_st_t rd_st;
  always_comb begin
    rd_st = '0;
    if (!tmr_en_i)
      rd_st = st_q[PH_IW'(chan)];
    else if (chan < CH_AW'(N_GRP))
      rd_st = voted[chan[GRP_IW-1:0]];
  end

  always_comb begin
    unique case (rsel)
      2'd0:    rdata_o = CNT_W'(rd_st.ctrl);
      2'd1:    rdata_o = rd_st.cnt;
      2'd2:    rdata_o = rd_st.cmp;
      default: rdata_o = CNT_W'(rd_st.flag);
    endcase
  end

  // interrupts
  for (genvar c = 0; c < N_VIS; c++) begin : g_irq
    if (c < N_GRP) begin : g_grp
      assign irq_o[c] = tmr_en_i ? (voted[c].flag & voted[c].ctrl.ie)
                                 : (st_q[c].flag & st_q[c].ctrl.ie);
    end else begin : g_solo
      assign irq_o[c] = !tmr_en_i && st_q[c].flag && st_q[c].ctrl.ie;
    end
  end

  AST_HIDDEN_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_en_i |-> irq_o[N_VIS-1:N_GRP] == '0); // R12
endmodule

// File: tb/sim_tmr_counter_bank.sv
`timescale 1ns/1ps
module sim_tmr_counter_bank;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tmr_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [255:0] events = '0;
  logic [7:0]  irq;
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  tmr_counter_bank u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tmr_en_i(tmr_en), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .events_i(events), .irq_o(irq)
  );

  // {req[3:0], op[1:0], addr[4:0], data/expected[31:0]}; op 0 write, 1 read, 2 idle, 3 irq
  localparam int NV = 31;
  localparam logic [42:0] VEC [NV] = '{
    {4'd1, 2'd1, 3'd0, 2'd1, 32'h0},          // R1 count reset
    {4'd1, 2'd1, 3'd3, 2'd0, 32'h0},          // R1 ctrl reset
    {4'd1, 2'd3, 5'd0,       32'h0},          // R1 irq reset
    {4'd2, 2'd0, 3'd0, 2'd2, 32'h123},        // R2 compare write
    {4'd2, 2'd1, 3'd0, 2'd2, 32'h123},
    {4'd2, 2'd0, 3'd0, 2'd0, 32'hFFFF_FFFF},  // R2 unused ctrl bits
    {4'd2, 2'd1, 3'd0, 2'd0, 32'h7FF},
    {4'd3, 2'd0, 3'd0, 2'd0, 32'h1},          // R3 timer on
    {4'd3, 2'd2, 5'd0,       32'd10},
    {4'd3, 2'd1, 3'd0, 2'd1, 32'd10},
    {4'd3, 2'd0, 3'd0, 2'd0, 32'h0},          // R3 off
    {4'd3, 2'd2, 5'd0,       32'd5},
    {4'd3, 2'd1, 3'd0, 2'd1, 32'd11},
    {4'd5, 2'd0, 3'd4, 2'd1, 32'hFFFF_FFFE},  // R5 wrap
    {4'd5, 2'd0, 3'd4, 2'd0, 32'h1},
    {4'd5, 2'd2, 5'd0,       32'd3},
    {4'd5, 2'd1, 3'd4, 2'd1, 32'd1},
    {4'd6, 2'd0, 3'd2, 2'd2, 32'd5},          // R6 match
    {4'd6, 2'd0, 3'd2, 2'd0, 32'h401},
    {4'd6, 2'd2, 5'd0,       32'd5},
    {4'd6, 2'd3, 5'd0,       32'h0},
    {4'd6, 2'd2, 5'd0,       32'd1},
    {4'd7, 2'd3, 5'd0,       32'h4},          // R7 irq raised
    {4'd6, 2'd1, 3'd2, 2'd3, 32'h1},
    {4'd6, 2'd0, 3'd2, 2'd0, 32'h400},
    {4'd6, 2'd0, 3'd2, 2'd3, 32'h0},          // R6 write 0 no effect
    {4'd6, 2'd3, 5'd0,       32'h4},
    {4'd6, 2'd0, 3'd2, 2'd3, 32'h1},          // R6 clear
    {4'd6, 2'd3, 5'd0,       32'h0},
    {4'd7, 2'd1, 3'd4, 2'd3, 32'h1},          // R7 flag set, ie low, irq low above
    {4'd8, 2'd1, 3'd5, 2'd1, 32'h0}           // R8 untouched channel
  };

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int req, input logic [4:0] a, input logic [31:0] exp);
    addr = a;
    #0.5;
    chk(req, rdata, exp, $sformatf("read addr %0d", a));
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; tmr_en = 1'b0; wr_en = 1'b0; events = '0;
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R0 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    do_reset();
    for (int i = 0; i < NV; i++) begin
      logic [42:0] v;
      v = VEC[i];
      case (v[38:37])
        2'd0: wr(v[36:32], v[31:0]);
        2'd1: rd(int'(v[42:39]), v[36:32], v[31:0]);
        2'd2: repeat (v[31:0]) @(negedge clk);
        default: begin #0.5; chk(int'(v[42:39]), {24'h0, irq}, v[31:0], "irq_o"); end
      endcase
    end

    // R4 event counting on line 200
    wr({3'd1, 2'd1}, 32'h0);
    wr({3'd1, 2'd0}, 32'h323);
    events[199] = 1'b1;
    repeat (3) @(negedge clk);
    rd(4, {3'd1, 2'd1}, 32'd0);               // R4 other line ignored
    events[199] = 1'b0; events[200] = 1'b1;
    repeat (4) @(negedge clk);
    events[200] = 1'b0;
    repeat (2) @(negedge clk);
    rd(4, {3'd1, 2'd1}, 32'd4);               // R4 selected line counted

    // R10 / R11 voting and write-back
    do_reset();
    wr({3'd0, 2'd2}, 32'h0F); wr({3'd1, 2'd2}, 32'h33); wr({3'd2, 2'd2}, 32'h55);
    wr({3'd0, 2'd1}, 32'd5);  wr({3'd1, 2'd1}, 32'd5);  wr({3'd2, 2'd1}, 32'd9);
    tmr_en = 1'b1;
    rd(10, {3'd0, 2'd2}, 32'h17);             // R10 bitwise majority
    rd(10, {3'd0, 2'd1}, 32'd5);
    @(negedge clk);
    tmr_en = 1'b0;
    rd(11, {3'd2, 2'd1}, 32'd5);              // R11 outlier corrected
    rd(11, {3'd0, 2'd2}, 32'h17);
    rd(11, {3'd2, 2'd2}, 32'h17);

    // R9 / R10 / R12 logical group 1
    tmr_en = 1'b1;
    wr({3'd1, 2'd1}, 32'd0);
    wr({3'd1, 2'd2}, 32'd3);
    wr({3'd1, 2'd0}, 32'h401);
    repeat (3) @(negedge clk);
    #0.5; chk(10, {24'h0, irq}, 32'h0, "irq_o before match");
    @(negedge clk);
    #0.5; chk(10, {24'h0, irq}, 32'h2, "irq_o voted");
    wr({3'd5, 2'd2}, 32'h77);                 // R12 ignored
    rd(12, {3'd5, 2'd2}, 32'h0);
    rd(12, {3'd5, 2'd0}, 32'h0);
    #0.5; chk(12, {24'h0, irq}, 32'h2, "irq_o hidden lanes");
    tmr_en = 1'b0;
    rd(12, {3'd5, 2'd2}, 32'd3);              // R12 write did not land
    rd(9, {3'd3, 2'd0}, 32'h401);             // R9 broadcast
    rd(9, {3'd4, 2'd0}, 32'h401);
    rd(9, {3'd5, 2'd0}, 32'h401);
    #0.5; chk(9, {24'h0, irq}, 32'h38, "irq_o members");
    finish_run();
  end
endmodule